// File: doc/BRIEF.md
# Power-Fail Event Logger

This block records power-fail events as compact records and keeps them in a bounded, append-only log in internal registers. When a power-fail trigger arrives, a fixed sequencer asks the system to enter reset. It then stores the event's cause code and then its timestamp. Only after both are stored does it ask for the switch to the backup supply. Each record holds a cause code, the time as a seconds count and as a BCD calendar value, a sequence number supplied with the event, and a CRC-8 over the record's fields.

Several cause sources may be active together. A fixed two-level priority picks the one that is recorded. Anti-replay logic accepts a record only when its sequence number is newer than the last one stored. A retried write that repeats a sequence number therefore never makes a duplicate. A host register port reads any retained record through a read index. The same port can lock the log for good or clear it under an explicit enable.

Top module: `pf_event_log`

## Requirements
- R1: Reset and switch order. The trigger `pf_req` is seen high at a clock edge while the block is idle. From the next cycle, `rst_req` is 1. The cause is written in the second cycle and the timestamp in the third. `bkp_req` rises in the fourth cycle after that edge. Both requests stay high until `pf_req` is seen low. Both then drop in the next cycle. This happens whether or not the record is stored.
- R2: Cause codes and priority. Bit i of `pf_src` means cause code i+1: 1 undervoltage, 2 brown-out, 3 manual, 4 MCU request, 5 watchdog, 6 thermal. Codes 1, 2 and 6 are high priority; the others are medium. The recorded code is the lowest active high-priority code. If no high-priority code is active, it is the lowest active medium one. With no source active, code 0 is recorded.
- R3: Record readback. Address 0x10 returns the cause, 0x12 the seconds count and 0x16 BCD digits hhmmss plus day (bits 31:0 of YYMMDDhhmmss). Address 0x18 returns the YYMM digits (bits 47:32), 0x1C the sequence number and 0x1A the CRC. The record shown is the one picked by the read index written at 0x20. Index 0 is the newest record.
- R4: CRC. The CRC is CRC-8 with polynomial 0x07 and initial value 0, with no reflection and no final XOR. It is computed MSB first over the cause byte, then the seconds count, then the sequence number.
- R5: The log holds DEPTH records. A store into a full log evicts the oldest record. A read index that is not below the number of retained records returns 0 at every record address.
- R6: Anti-replay. The first record after reset is always accepted. After that, an event whose sequence number is equal to or below the last stored one is not stored, and the log is unchanged.
- R7: Lock. Writing 1 to bit 0 at 0x1E locks the log until reset. While it is locked, no record is stored and no clear takes effect. The reset and switch sequence of R1 still runs.
- R8: Clear. A write at 0x1E keeps bit 1 as the clear enable. A later write with bit 2 set empties the log, but only if the stored enable is already 1, the log is not locked and no event is in progress. Clearing does not forget the last stored sequence number.
- R9: After reset both requests are 0 and the log is empty. Address 0x1E, the read-index address and unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pf_req | input | 1 | Power-fail trigger, level |
| pf_src | input | NUM_SRC | Active cause sources, bit i = code i+1 |
| pf_seq | input | SEQ_W | Sequence number carried by the event |
| now_secs | input | SEC_W | Current time as a seconds count |
| now_bcd | input | 48 | Current time as BCD YYMMDDhhmmss |
| reg_addr | input | 8 | Host register address |
| reg_wr | input | 1 | Host write strobe |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data for `reg_addr`, combinational |
| rst_req | output | 1 | Request to hold the system in reset |
| bkp_req | output | 1 | Request to switch to the backup supply |

## Verification
The assertions assume three things. The cause, time and sequence inputs stay stable for the whole event. The lock is not set while an event is in progress. Host clear writes are issued only while the sequencer is idle. The bench holds every event input constant from the trigger until `pf_req` is released, and issues lock and clear writes only between events. Under these conditions the ordering, bound, monotonic and lock-freeze properties hold. The stimulus sweeps every combination of cause sources against an arithmetic priority model. Replayed, equal and stale sequence numbers are sent after clears and under lock. After each step, the bench walks every read index, including one past the end.

// File: rtl/pflog_pkg.sv
package pflog_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE   = 3'd0,
      SQ_RESET  = 3'd1,
      SQ_REASON = 3'd2,
      SQ_STAMP  = 3'd3,
      SQ_HOLD   = 3'd4
   } sq_state_t;

   localparam logic [7:0] A_REASON = 8'h10;
   localparam logic [7:0] A_SECS   = 8'h12;
   localparam logic [7:0] A_BCD_LO = 8'h16;
   localparam logic [7:0] A_BCD_HI = 8'h18;
   localparam logic [7:0] A_CRC    = 8'h1A;
   localparam logic [7:0] A_SEQ    = 8'h1C;
   localparam logic [7:0] A_CTRL   = 8'h1E;
   localparam logic [7:0] A_RIDX   = 8'h20;

   localparam int C_LOCK   = 0;
   localparam int C_CLR_EN = 1;
   localparam int C_CLR_GO = 2;

   localparam int BCD_W  = 48;
   localparam int CODE_W = 8;
   localparam int REG_W  = 32;

   function automatic logic [7:0] crc8_bit(input logic [7:0] c, input logic b);
      logic fb;
      fb = c[7] ^ b;
      return fb ? ({c[6:0], 1'b0} ^ 8'h07) : {c[6:0], 1'b0};
   endfunction

endpackage

// File: rtl/pflog_prio.sv
module pflog_prio #(
   parameter int NUM_SRC = 6,
   parameter logic [NUM_SRC-1:0] HIGH_MASK = 6'b100011
) (
   input  logic [NUM_SRC-1:0]         src,
   output logic [pflog_pkg::CODE_W-1:0] code
);
   import pflog_pkg::*;

   logic [NUM_SRC-1:0] hi_act, md_act;
   logic [CODE_W-1:0]  hi_code [NUM_SRC+1];
   logic [CODE_W-1:0]  md_code [NUM_SRC+1];

   assign hi_act = src & HIGH_MASK;
   assign md_act = src & ~HIGH_MASK;

   assign hi_code[NUM_SRC] = '0;
   assign md_code[NUM_SRC] = '0;

   // chain from the top index down so the lowest active index wins per level
   for (genvar i = NUM_SRC - 1; i >= 0; i--) begin : g_chain
      assign hi_code[i] = hi_act[i] ? CODE_W'(i + 1) : hi_code[i+1];
      assign md_code[i] = md_act[i] ? CODE_W'(i + 1) : md_code[i+1];
   end

   assign code = (|hi_act) ? hi_code[0] : md_code[0];

endmodule

// File: rtl/pflog_crc8.sv
module pflog_crc8 #(
   parameter int DATA_W = 56
) (
   input  logic [DATA_W-1:0] data,
   output logic [7:0]        crc
);
   import pflog_pkg::*;

   always_comb begin
      crc = 8'h00;
      for (int i = DATA_W - 1; i >= 0; i--) begin
         crc = crc8_bit(crc, data[i]);
      end
   end

endmodule

// File: rtl/pflog_seq.sv
module pflog_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic pf_req,
   output logic ph_capture,
   output logic ph_reason,
   output logic ph_stamp,
   output logic idle,
   output logic rst_req,
   output logic bkp_req
);
   import pflog_pkg::*;

   sq_state_t st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         SQ_IDLE:   if (pf_req) st_d = SQ_RESET;
         SQ_RESET:  st_d = SQ_REASON;
         SQ_REASON: st_d = SQ_STAMP;
         SQ_STAMP:  st_d = SQ_HOLD;
         SQ_HOLD:   if (!pf_req) st_d = SQ_IDLE;
         default:   st_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= SQ_IDLE;
      else        st_q <= st_d;
   end

   assign idle       = (st_q == SQ_IDLE);
   assign ph_capture = idle && pf_req;
   assign ph_reason  = (st_q == SQ_REASON);
   assign ph_stamp   = (st_q == SQ_STAMP);
   assign rst_req    = !idle;
   assign bkp_req    = (st_q == SQ_HOLD);

endmodule

// File: rtl/pflog_ring.sv
module pflog_ring #(
   parameter int DEPTH = 4,
   parameter int SEC_W = 32,
   parameter int SEQ_W = 16,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = IDX_W + 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        reason_we,
   input  logic [pflog_pkg::CODE_W-1:0] reason_d,
   input  logic                        commit,
   input  logic [SEC_W-1:0]            secs_d,
   input  logic [pflog_pkg::BCD_W-1:0] bcd_d,
   input  logic [SEQ_W-1:0]            seq_d,
   input  logic [7:0]                  crc_d,
   input  logic                        clear,
   input  logic [CNT_W-1:0]            rd_idx,
   output logic [pflog_pkg::CODE_W-1:0] rd_reason,
   output logic [SEC_W-1:0]            rd_secs,
   output logic [pflog_pkg::BCD_W-1:0] rd_bcd,
   output logic [SEQ_W-1:0]            rd_seq,
   output logic [7:0]                  rd_crc,
   output logic [CNT_W-1:0]            count
);
   import pflog_pkg::*;

   logic [CODE_W-1:0] m_reason [DEPTH];
   logic [SEC_W-1:0]  m_secs   [DEPTH];
   logic [BCD_W-1:0]  m_bcd    [DEPTH];
   logic [SEQ_W-1:0]  m_seq    [DEPTH];
   logic [7:0]        m_crc    [DEPTH];

   logic [IDX_W-1:0] wptr_q;
   logic [CNT_W-1:0] cnt_q;
   logic [IDX_W-1:0] slot;
   logic             rd_valid;

   // storage: the cause field lands one cycle ahead of the rest
   always_ff @(posedge clk) begin
      for (int s = 0; s < DEPTH; s++) begin
         if (reason_we && wptr_q == IDX_W'(s)) m_reason[s] <= reason_d;
         if (commit && wptr_q == IDX_W'(s)) begin
            m_secs[s] <= secs_d;
            m_bcd[s]  <= bcd_d;
            m_seq[s]  <= seq_d;
            m_crc[s]  <= crc_d;
         end
      end
   end

   // the oldest entry leaves when its slot is first touched, never shown half-written
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
         cnt_q  <= '0;
      end else if (clear) begin
         wptr_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (reason_we && cnt_q == CNT_W'(DEPTH)) cnt_q <= cnt_q - 1'b1;
         if (commit) begin
            wptr_q <= wptr_q + 1'b1;
            if (cnt_q != CNT_W'(DEPTH)) cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign count    = cnt_q;
   assign rd_valid = rd_idx < cnt_q;
   assign slot     = wptr_q - IDX_W'(1) - rd_idx[IDX_W-1:0];

   assign rd_reason = rd_valid ? m_reason[slot] : '0;
   assign rd_secs   = rd_valid ? m_secs[slot]   : '0;
   assign rd_bcd    = rd_valid ? m_bcd[slot]    : '0;
   assign rd_seq    = rd_valid ? m_seq[slot]    : '0;
   assign rd_crc    = rd_valid ? m_crc[slot]    : '0;

endmodule

// File: rtl/pf_event_log.sv
module pf_event_log #(
   parameter int NUM_SRC = 6,
   parameter logic [NUM_SRC-1:0] HIGH_MASK = 6'b100011,
   parameter int DEPTH = 4,
   parameter int SEC_W = 32,
   parameter int SEQ_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pf_req,
   input  logic [NUM_SRC-1:0] pf_src,
   input  logic [SEQ_W-1:0]   pf_seq,
   input  logic [SEC_W-1:0]   now_secs,
   input  logic [47:0]        now_bcd,
   input  logic [7:0]         reg_addr,
   input  logic               reg_wr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   output logic               rst_req,
   output logic               bkp_req
);
   import pflog_pkg::*;

   localparam int IDX_W = $clog2(DEPTH);
   localparam int CNT_W = IDX_W + 1;
   localparam int CRC_IN_W = CODE_W + SEC_W + SEQ_W;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("pf_event_log: DEPTH must be a power of two, at least 2");
   end
   if (SEC_W % 8 != 0 || SEC_W > REG_W) begin : g_bad_sec
      $error("pf_event_log: SEC_W must be whole bytes and fit a register");
   end
   if (SEQ_W % 8 != 0 || SEQ_W > REG_W) begin : g_bad_seq
      $error("pf_event_log: SEQ_W must be whole bytes and fit a register");
   end
   if (NUM_SRC < 1 || NUM_SRC > 255) begin : g_bad_src
      $error("pf_event_log: NUM_SRC out of range");
   end

   logic ph_capture, ph_reason, ph_stamp, idle;

   pflog_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .pf_req     (pf_req),
      .ph_capture (ph_capture),
      .ph_reason  (ph_reason),
      .ph_stamp   (ph_stamp),
      .idle       (idle),
      .rst_req    (rst_req),
      .bkp_req    (bkp_req)
   );

   logic [CODE_W-1:0] win_code;

   pflog_prio #(.NUM_SRC(NUM_SRC), .HIGH_MASK(HIGH_MASK)) u_prio (
      .src  (pf_src),
      .code (win_code)
   );

   // event capture and replay decision
   logic [CODE_W-1:0] cap_reason;
   logic [SEC_W-1:0]  cap_secs;
   logic [BCD_W-1:0]  cap_bcd;
   logic [SEQ_W-1:0]  cap_seq;
   logic              acc_q;
   logic              seen_q;
   logic [SEQ_W-1:0]  last_seq_q;
   logic              lock_q, clr_en_q;
   logic              fresh;

   assign fresh = !seen_q || (pf_seq > last_seq_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_reason <= '0;
         cap_secs   <= '0;
         cap_bcd    <= '0;
         cap_seq    <= '0;
         acc_q      <= 1'b0;
      end else if (ph_capture) begin
         cap_reason <= win_code;
         cap_secs   <= now_secs;
         cap_bcd    <= now_bcd;
         cap_seq    <= pf_seq;
         acc_q      <= fresh;
      end
   end

   logic reason_we, commit;
   assign reason_we = ph_reason && acc_q && !lock_q;
   assign commit    = ph_stamp  && acc_q && !lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q     <= 1'b0;
         last_seq_q <= '0;
      end else if (commit) begin
         seen_q     <= 1'b1;
         last_seq_q <= cap_seq;
      end
   end

   logic [7:0] rec_crc;

   pflog_crc8 #(.DATA_W(CRC_IN_W)) u_crc (
      .data ({cap_reason, cap_secs, cap_seq}),
      .crc  (rec_crc)
   );

   // host control
   logic ctrl_wr, clear;
   logic [CNT_W-1:0] ridx_q;

   assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
   assign clear   = ctrl_wr && reg_wdata[C_CLR_GO] && clr_en_q && !lock_q && idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q   <= 1'b0;
         clr_en_q <= 1'b0;
         ridx_q   <= '0;
      end else begin
         if (ctrl_wr) begin
            lock_q   <= lock_q | reg_wdata[C_LOCK];
            clr_en_q <= reg_wdata[C_CLR_EN];
         end
         if (reg_wr && reg_addr == A_RIDX) ridx_q <= reg_wdata[CNT_W-1:0];
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^reg_wdata;

   logic [CODE_W-1:0] rd_reason;
   logic [SEC_W-1:0]  rd_secs;
   logic [BCD_W-1:0]  rd_bcd;
   logic [SEQ_W-1:0]  rd_seq;
   logic [7:0]        rd_crc;
   logic [CNT_W-1:0]  count;

   pflog_ring #(.DEPTH(DEPTH), .SEC_W(SEC_W), .SEQ_W(SEQ_W)) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .reason_we (reason_we),
      .reason_d  (cap_reason),
      .commit    (commit),
      .secs_d    (cap_secs),
      .bcd_d     (cap_bcd),
      .seq_d     (cap_seq),
      .crc_d     (rec_crc),
      .clear     (clear),
      .rd_idx    (ridx_q),
      .rd_reason (rd_reason),
      .rd_secs   (rd_secs),
      .rd_bcd    (rd_bcd),
      .rd_seq    (rd_seq),
      .rd_crc    (rd_crc),
      .count     (count)
   );

   always_comb begin
      unique case (reg_addr)
         A_REASON: reg_rdata = REG_W'(rd_reason);
         A_SECS:   reg_rdata = REG_W'(rd_secs);
         A_BCD_LO: reg_rdata = rd_bcd[31:0];
         A_BCD_HI: reg_rdata = REG_W'(rd_bcd[47:32]);
         A_CRC:    reg_rdata = REG_W'(rd_crc);
         A_SEQ:    reg_rdata = REG_W'(rd_seq);
         default:  reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/pflog_chk.sv
module pflog_chk #(
   parameter int DEPTH = 4,
   parameter int SEQ_W = 16,
   localparam int CNT_W = $clog2(DEPTH) + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rst_req,
   input logic             bkp_req,
   input logic             ph_reason,
   input logic             ph_stamp,
   input logic             lock_q,
   input logic             seen_q,
   input logic [SEQ_W-1:0] last_seq_q,
   input logic [CNT_W-1:0] count
);

   // R1: the backup request never stands without the reset request
   a_r1_bkp_under_rst: assert property (@(posedge clk) disable iff (!rst_n)
      bkp_req |-> rst_req);

   // R1: the cause phase follows a cycle that already held reset
   a_r1_reason_after_rst: assert property (@(posedge clk) disable iff (!rst_n)
      ph_reason |-> $past(rst_req));

   // R1: timestamp phase directly follows the cause phase
   a_r1_stamp_after_reason: assert property (@(posedge clk) disable iff (!rst_n)
      ph_stamp |-> $past(ph_reason));

   // R1: switchover only right after the timestamp phase
   a_r1_bkp_after_stamp: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bkp_req) |-> $past(ph_stamp));

   // R5: retained count never exceeds the depth
   a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   // R6: the stored sequence number never goes backwards
   a_r6_seq_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && $past(seen_q)) |-> (last_seq_q >= $past(last_seq_q)));

   // R7: once locked, the log contents do not change
   a_r7_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      $past(lock_q) |-> ($stable(count) && $stable(last_seq_q)));

   // R7: the lock never releases without reset
   a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $past(lock_q) |-> lock_q);

endmodule

bind pf_event_log pflog_chk #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rst_req    (rst_req),
   .bkp_req    (bkp_req),
   .ph_reason  (ph_reason),
   .ph_stamp   (ph_stamp),
   .lock_q     (lock_q),
   .seen_q     (seen_q),
   .last_seq_q (last_seq_q),
   .count      (count)
);

// File: tb/sim_pf_event_log.sv
`timescale 1ns/1ps
module sim_pf_event_log;

   localparam int DEPTH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pf_req = 1'b0;
   logic [5:0]  pf_src = '0;
   logic [15:0] pf_seq = '0;
   logic [31:0] now_secs = '0;
   logic [47:0] now_bcd = '0;
   logic [7:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        rst_req, bkp_req;

   always #2 clk = ~clk;

   pf_event_log u0 (
      .clk(clk), .rst_n(rst_n), .pf_req(pf_req), .pf_src(pf_src), .pf_seq(pf_seq),
      .now_secs(now_secs), .now_bcd(now_bcd), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rst_req(rst_req), .bkp_req(bkp_req)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   // reference log, index 0 newest
   logic [7:0]  e_reason [DEPTH];
   logic [31:0] e_secs   [DEPTH];
   logic [47:0] e_bcd    [DEPTH];
   logic [15:0] e_seq    [DEPTH];
   int          m_cnt = 0;
   bit          m_seen = 0;
   logic [15:0] m_last = '0;
   bit          m_lock = 0;
   bit          m_clr_en = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_code(input logic [5:0] s);
      // high level: codes 1,2,6 ; medium: 3,4,5 ; lower code first
      if (s[0]) return 8'd1;
      if (s[1]) return 8'd2;
      if (s[5]) return 8'd6;
      if (s[2]) return 8'd3;
      if (s[3]) return 8'd4;
      if (s[4]) return 8'd5;
      return 8'd0;
   endfunction

   function automatic logic [7:0] exp_crc(input logic [7:0] r, input logic [31:0] s, input logic [15:0] q);
      logic [55:0] d;
      logic [7:0]  c;
      d = {r, s, q};
      c = 8'h00;
      for (int by = 6; by >= 0; by--) begin
         c = c ^ d[by*8 +: 8];
         for (int b = 0; b < 8; b++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
      end
      return c;
   endfunction

   function automatic logic [7:0] bcd2(input int v);
      return {4'(v / 10), 4'(v % 10)};
   endfunction

   task automatic host_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic host_rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic verify_log(input string req);
      logic [31:0] d;
      for (int k = 0; k <= DEPTH; k++) begin
         bit v;
         v = (k < m_cnt);
         host_wr(8'h20, 32'(k));
         host_rd(8'h10, d); chk({req, " R3 cause"}, d, v ? 32'(e_reason[k]) : 0);
         host_rd(8'h12, d); chk({req, " R3 secs"},  d, v ? e_secs[k] : 0);
         host_rd(8'h16, d); chk({req, " R3 bcd lo"}, d, v ? e_bcd[k][31:0] : 0);
         host_rd(8'h18, d); chk({req, " R3 bcd hi"}, d, v ? 32'(e_bcd[k][47:32]) : 0);
         host_rd(8'h1C, d); chk({req, " R3 seq"},   d, v ? 32'(e_seq[k]) : 0);
         host_rd(8'h1A, d); chk({req, " R4 crc"},   d,
                                v ? 32'(exp_crc(e_reason[k], e_secs[k], e_seq[k])) : 0);
      end
   endtask

   task automatic run_event(input logic [5:0] src, input logic [15:0] seq,
                            input logic [31:0] secs, input logic [47:0] bcd);
      bit acc;
      @(negedge clk);
      pf_src = src; pf_seq = seq; now_secs = secs; now_bcd = bcd; pf_req = 1'b1;
      for (int n = 1; n <= 4; n++) begin
         @(negedge clk);
         chk("R1 rst_req during event", 32'(rst_req), 1);
         chk("R1 bkp_req order", 32'(bkp_req), (n == 4) ? 1 : 0);
      end
      pf_req = 1'b0;
      @(negedge clk);
      chk("R1 rst_req released", 32'(rst_req), 0);
      chk("R1 bkp_req released", 32'(bkp_req), 0);
      acc = !m_lock && (!m_seen || seq > m_last);
      if (acc) begin
         for (int k = DEPTH - 1; k > 0; k--) begin
            e_reason[k] = e_reason[k-1]; e_secs[k] = e_secs[k-1];
            e_bcd[k] = e_bcd[k-1]; e_seq[k] = e_seq[k-1];
         end
         e_reason[0] = exp_code(src); e_secs[0] = secs; e_bcd[0] = bcd; e_seq[0] = seq;
         if (m_cnt < DEPTH) m_cnt++;
         m_seen = 1; m_last = seq;
      end
   endtask

   task automatic ctrl_wr(input logic [31:0] d);
      host_wr(8'h1E, d);
      if (d[2] && m_clr_en && !m_lock) m_cnt = 0;
      m_clr_en = d[1];
      if (d[0]) m_lock = 1;
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state
      chk("R9 rst_req after reset", 32'(rst_req), 0);
      chk("R9 bkp_req after reset", 32'(bkp_req), 0);
      verify_log("R9 empty");

      // R2/R5: sweep all source combinations, log wraps many times
      for (int v = 0; v < 64; v++) begin
         run_event(6'(v), 16'(10 + v * 3), 32'h1000_0000 + 32'(v * 37),
                   {8'h25, bcd2(v % 12 + 1), bcd2(v % 28 + 1), bcd2(v % 24),
                    bcd2(v % 60), bcd2((v * 7) % 60)});
         host_wr(8'h20, 0);
         host_rd(8'h10, d);
         chk("R2 priority code", d, 32'(exp_code(6'(v))));
         if (v % 8 == 7) verify_log("R5 wrap");
      end

      // R6: equal (retry) and stale sequence numbers rejected
      run_event(6'b000001, m_last, 32'hAAAA_0001, 48'h2501_0101_0101);
      verify_log("R6 retry no duplicate");
      run_event(6'b000100, m_last - 16'd5, 32'hAAAA_0002, 48'h2501_0101_0102);
      verify_log("R6 stale rejected");
      run_event(6'b000100, m_last + 16'd1, 32'hAAAA_0003, 48'h2501_0101_0103);
      verify_log("R6 newer accepted");

      // R8: clear without enable has no effect
      ctrl_wr(32'h4);
      verify_log("R8 clear without enable");
      ctrl_wr(32'h2);
      ctrl_wr(32'h6);
      verify_log("R8 clear with enable");
      // R8: anti-replay survives clear
      run_event(6'b001000, m_last, 32'hBBBB_0001, 48'h2502_0202_0202);
      verify_log("R8 replay after clear");
      for (int j = 1; j <= 5; j++)
         run_event(6'(j), m_last + 16'(j), 32'hBBBB_0010 + 32'(j), 48'h2502_0202_0300 + 48'(j));
      verify_log("R5 refill and evict");

      // R9: write-only and unmapped addresses read zero
      host_rd(8'h1E, d); chk("R9 control reads zero", d, 0);
      host_rd(8'h20, d); chk("R9 index reads zero", d, 0);
      host_rd(8'h11, d); chk("R9 unmapped reads zero", d, 0);

      // R7: lock blocks store and clear, sequence still runs
      ctrl_wr(32'h3);
      run_event(6'b100000, m_last + 16'd100, 32'hCCCC_0001, 48'h2503_0303_0303);
      verify_log("R7 locked store blocked");
      ctrl_wr(32'h6);
      verify_log("R7 locked clear blocked");

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule